// File: doc/BRIEF.md
# CAN Two-Slot Receive Store with Overrun Flag

This block sits between a CAN receive engine and the CPU. It holds up to two accepted messages, tells the CPU whether a received message is waiting, flags data overrun and drives a level receive interrupt. When the engine delivers a message and every slot is taken, the message is lost and the sticky overrun flag is raised. The engine also hands over frames that this node is sending itself, because arbitration may still be lost. Such a frame takes a slot but stays hidden from the CPU. When the engine reports that the transmission won, the entry is discarded. When it reports that arbitration was lost, the entry turns into an ordinary received message.

Incoming messages use a valid/ready stream. `in_ready` is always high: the block never applies back-pressure, and it stores or drops each beat in the cycle it is offered. The CPU side is also valid/ready. `rd_valid` is the receive-buffer-status flag and `rd_data` shows the oldest visible message. A handshake on `rd_ready` is the release command and frees that message's slot. The remaining pins are plain control and status.

Top module: `can_rx_dual_buf`

## Requirements
- R1: After reset, no slot is occupied and `rd_valid`, `overrun` and `rx_irq` are 0. `in_ready` is 1 at all times.
- R2: A received message (`in_own`=0) offered while a slot is free is stored. In the next cycle `rd_valid` is 1 and `rd_data` shows the oldest stored received message.
- R3: Received messages are presented in arrival order. `rd_ready` while `rd_valid`=1 frees the presented slot. `rd_valid` falls once no received message remains.
- R4: A message offered while both slots were occupied at the start of the cycle is dropped, even if a release or discard happens in that same cycle. `overrun` is 1 from the next cycle and the stored contents are unchanged.
- R5: An own message (`in_own`=1) that is stored takes a slot but does not set `rd_valid` and does not raise `rx_irq`.
- R6: An own message offered while both slots are occupied sets `overrun`.
- R7: `tx_done` discards the pending own entry and frees its slot.
- R8: `tx_lost` turns the pending own entry into a received message, which keeps its arrival position in the read order.
- R9: `overrun` stays 1 until `ovr_clear`. If a new overrun and `ovr_clear` occur in the same cycle, the flag stays set.
- R10: `rx_irq` is high exactly while `rd_valid` and `irq_en` are both 1.
- R11: `rd_ready` while `rd_valid`=0 has no effect on stored messages or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Engine offers one accepted message |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_own | input | 1 | Offered message is this node's own transmission |
| in_data | input | DATA_W | Message data word |
| tx_done | input | 1 | Own transmission won arbitration and completed |
| tx_lost | input | 1 | Own transmission lost arbitration |
| rd_valid | output | 1 | Receive-buffer-status: a received message is waiting |
| rd_ready | input | 1 | Release command for the presented message |
| rd_data | output | DATA_W | Oldest waiting received message |
| ovr_clear | input | 1 | Clear the overrun flag |
| irq_en | input | 1 | Receive interrupt enable |
| overrun | output | 1 | Sticky data-overrun flag |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
The assertions assume that the engine has at most one own frame in flight. They also assume that it never offers a second own message while one is pending, and that `tx_done` and `tx_lost` never occur in the same cycle. The sweep holds to these rules by tracking in its reference model whether an own entry is pending. While one is, it replaces a scheduled own arrival with an idle cycle, and it issues only one command per cycle. The directed cases drive the concurrent corners separately: a release or clear in the same cycle as an arrival into full slots.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic {
    ENT_RX  = 1'b0,
    ENT_OWN = 1'b1
  } ent_kind_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBUF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  ent_kind_e         push_kind,
  input  logic [DATA_W-1:0] push_data,
  input  logic [NBUF-1:0]   rm_mask,
  input  logic              promote,
  output logic [NBUF-1:0]   slot_vld,
  output logic [NBUF-1:0]   slot_own,
  output logic [DATA_W-1:0] slot_data [NBUF],
  output logic              full
);
  localparam int unsigned CNT_W = $clog2(NBUF + 1);

  logic [NBUF-1:0]   vld_q, vld_d;
  logic [NBUF-1:0]   own_q, own_d;
  logic [DATA_W-1:0] dat_q [NBUF];
  logic [DATA_W-1:0] dat_d [NBUF];
  logic [CNT_W-1:0]  k;

  assign full = &vld_q;

  // Compact surviving entries toward slot 0 (oldest), then append.
  always_comb begin
    vld_d = '0;
    own_d = '0;
    for (int i = 0; i < NBUF; i++) dat_d[i] = dat_q[i];
    k = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (vld_q[i] && !rm_mask[i]) begin
        for (int j = 0; j < NBUF; j++) begin
          if (k == CNT_W'(j)) begin
            vld_d[j] = 1'b1;
            own_d[j] = own_q[i] && !promote;
            dat_d[j] = dat_q[i];
          end
        end
        k = k + CNT_W'(1);
      end
    end
    if (push && !full) begin
      for (int j = 0; j < NBUF; j++) begin
        if (k == CNT_W'(j)) begin
          vld_d[j] = 1'b1;
          own_d[j] = (push_kind == ENT_OWN);
          dat_d[j] = push_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      own_q <= '0;
    end else begin
      vld_q <= vld_d;
      own_q <= own_d;
    end
  end

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (vld_d[g]) dat_q[g] <= dat_d[g];
      end
      assign slot_data[g] = dat_q[g];
    end
  endgenerate

  assign slot_vld = vld_q;
  assign slot_own = own_q & vld_q;

  // Input rule: a single own frame in flight (R5, R7, R8).
  assert_one_own_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_kind == ENT_OWN) |-> (slot_own == '0));
  assert_own_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_own) <= 1);
endmodule

// File: rtl/rxb_pick.sv
module rxb_pick #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBUF   = 2
) (
  input  logic [NBUF-1:0]   slot_vld,
  input  logic [NBUF-1:0]   slot_own,
  input  logic [DATA_W-1:0] slot_data [NBUF],
  output logic              any_rx,
  output logic [NBUF-1:0]   sel,
  output logic [DATA_W-1:0] sel_data
);
  logic [NBUF-1:0] rx_mask;
  assign rx_mask = slot_vld & ~slot_own;
  assign any_rx  = |rx_mask;

  // Lowest index is the oldest visible entry.
  always_comb begin
    sel      = '0;
    sel_data = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (rx_mask[i]) begin
        sel      = '0;
        sel[i]   = 1'b1;
        sel_data = slot_data[i];
      end
    end
  end
endmodule

// File: rtl/rxb_flags.sv
module rxb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_set,
  input  logic ovr_clear,
  input  logic any_rx,
  input  logic irq_en,
  output logic overrun,
  output logic rx_irq
);
  logic ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (ovr_set)   ovr_q <= 1'b1;
    else if (ovr_clear) ovr_q <= 1'b0;
  end

  assign overrun = ovr_q;
  assign rx_irq  = any_rx && irq_en;

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> irq_en);
endmodule

// File: rtl/can_rx_dual_buf.sv
module can_rx_dual_buf
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBUF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_own,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tx_done,
  input  logic              tx_lost,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ovr_clear,
  input  logic              irq_en,
  output logic              overrun,
  output logic              rx_irq
);
  logic [NBUF-1:0]   slot_vld, slot_own, sel, rm_mask;
  logic [DATA_W-1:0] slot_data [NBUF];
  logic              full, any_rx, release_hs;
  ent_kind_e         kind;

  assign in_ready   = 1'b1;
  assign kind       = in_own ? ENT_OWN : ENT_RX;
  assign release_hs = rd_ready && any_rx;
  assign rm_mask    = (release_hs ? sel : '0) | (tx_done ? slot_own : '0);

  rxb_store #(.DATA_W(DATA_W), .NBUF(NBUF)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .push_kind(kind), .push_data(in_data),
    .rm_mask(rm_mask), .promote(tx_lost),
    .slot_vld(slot_vld), .slot_own(slot_own), .slot_data(slot_data),
    .full(full)
  );

  rxb_pick #(.DATA_W(DATA_W), .NBUF(NBUF)) u_pick (
    .slot_vld(slot_vld), .slot_own(slot_own), .slot_data(slot_data),
    .any_rx(any_rx), .sel(sel), .sel_data(rd_data)
  );

  rxb_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovr_set(in_valid && full), .ovr_clear(ovr_clear),
    .any_rx(any_rx), .irq_en(irq_en),
    .overrun(overrun), .rx_irq(rx_irq)
  );

  assign rd_valid = any_rx;

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> overrun);
  assert_rx_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_own && !full) |=> rd_valid);
  assert_own_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_own && !full && !rd_valid && !tx_lost) |=> !rd_valid);
  assert_tx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_lost));
endmodule

// File: tb/sim_can_rx_dual_buf.sv
module sim_can_rx_dual_buf;
  localparam int NB = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_own = 0, tx_done = 0, tx_lost = 0, rd_ready = 0;
  logic ovr_clear = 0, irq_en = 0;
  logic [7:0] in_data = '0;
  logic in_ready, rd_valid, overrun, rx_irq;
  logic [7:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  bit mv [NB];
  bit mo [NB];
  logic [7:0] md [NB];
  bit movr;

  always #5 clk = ~clk;

  can_rx_dual_buf #(.DATA_W(8), .NBUF(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_own(in_own), .in_data(in_data), .tx_done(tx_done), .tx_lost(tx_lost),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ovr_clear(ovr_clear), .irq_en(irq_en), .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit own, input logic [7:0] d,
                     input bit rdy, input bit ok, input bit lost, input bit clr);
    @(negedge clk);
    in_valid = v; in_own = own; in_data = d; rd_ready = rdy;
    tx_done = ok; tx_lost = lost; ovr_clear = clr;
    @(posedge clk);
    #1;
    in_valid = 0; in_own = 0; rd_ready = 0; tx_done = 0; tx_lost = 0; ovr_clear = 0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1; rst_n = 1; #1;
    for (int i = 0; i < NB; i++) begin mv[i] = 0; mo[i] = 0; md[i] = '0; end
    movr = 0;
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < NB; i++) if (mv[i]) c++;
    return c;
  endfunction

  function automatic bit m_own_pending();
    for (int i = 0; i < NB; i++) if (mv[i] && mo[i]) return 1;
    return 0;
  endfunction

  function automatic void m_remove(input int idx);
    for (int i = idx; i < NB - 1; i++) begin
      mv[i] = mv[i+1]; mo[i] = mo[i+1]; md[i] = md[i+1];
    end
    mv[NB-1] = 0; mo[NB-1] = 0;
  endfunction

  // One command per cycle: 0 idle,1 rx,2 own,3 release,4 done,5 lost,6 clear
  function automatic void m_apply(input int op, input logic [7:0] d);
    int c = m_count();
    case (op)
      1, 2: if (c == NB) movr = 1;
            else begin mv[c] = 1; mo[c] = (op == 2); md[c] = d; end
      3: begin
           for (int i = 0; i < NB; i++)
             if (mv[i] && !mo[i]) begin m_remove(i); break; end
         end
      4: begin
           for (int i = 0; i < NB; i++)
             if (mv[i] && mo[i]) begin m_remove(i); break; end
         end
      5: for (int i = 0; i < NB; i++) mo[i] = 0;
      6: movr = 0;
      default: ;
    endcase
  endfunction

  task automatic m_check();
    bit ev = 0;
    logic [7:0] ed = '0;
    for (int i = NB - 1; i >= 0; i--) if (mv[i] && !mo[i]) begin ev = 1; ed = md[i]; end
    chk("R3 rd_valid", {7'd0, rd_valid}, {7'd0, ev});
    if (ev) chk("R2 rd_data", rd_data, ed);
    chk("R9 overrun", {7'd0, overrun}, {7'd0, movr});
    chk("R10 rx_irq", {7'd0, rx_irq}, {7'd0, ev & irq_en});
    chk("R1 in_ready", {7'd0, in_ready}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    irq_en = 1;
    do_reset();
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R1 overrun", {7'd0, overrun}, 8'd0);
    chk("R1 rx_irq", {7'd0, rx_irq}, 8'd0);
    chk("R1 in_ready", {7'd0, in_ready}, 8'd1);

    // R5 own message hidden, R2 rx visible, R4 full drop, R7 discard, R3 order, R11
    cyc(1, 1, 8'h5A, 0, 0, 0, 0);
    chk("R5 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R5 rx_irq", {7'd0, rx_irq}, 8'd0);
    cyc(1, 0, 8'hA1, 0, 0, 0, 0);
    chk("R2 rd_valid", {7'd0, rd_valid}, 8'd1);
    chk("R2 rd_data", rd_data, 8'hA1);
    chk("R10 rx_irq", {7'd0, rx_irq}, 8'd1);
    cyc(1, 0, 8'hB2, 0, 0, 0, 0);
    chk("R4 overrun", {7'd0, overrun}, 8'd1);
    chk("R4 rd_data", rd_data, 8'hA1);
    cyc(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R9 cleared", {7'd0, overrun}, 8'd0);
    cyc(0, 0, 8'h00, 0, 1, 0, 0);
    cyc(1, 0, 8'hB2, 0, 0, 0, 0);
    chk("R7 slot freed", {7'd0, overrun}, 8'd0);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R3 second", rd_data, 8'hB2);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R3 empty", {7'd0, rd_valid}, 8'd0);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R11 rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R11 overrun", {7'd0, overrun}, 8'd0);
    cyc(1, 0, 8'hC3, 0, 0, 0, 0);
    cyc(1, 0, 8'hC4, 0, 0, 0, 0);
    chk("R11 no slot lost", {7'd0, overrun}, 8'd0);
    chk("R11 data", rd_data, 8'hC3);

    // R6 own message into full slots
    do_reset();
    cyc(1, 0, 8'h11, 0, 0, 0, 0);
    cyc(1, 0, 8'h22, 0, 0, 0, 0);
    cyc(1, 1, 8'h33, 0, 0, 0, 0);
    chk("R6 overrun", {7'd0, overrun}, 8'd1);
    chk("R6 rd_data", rd_data, 8'h11);

    // R8 lost arbitration keeps arrival order
    do_reset();
    cyc(1, 1, 8'h44, 0, 0, 0, 0);
    cyc(1, 0, 8'h55, 0, 0, 0, 0);
    chk("R8 before", rd_data, 8'h55);
    cyc(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R8 promoted", rd_data, 8'h44);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R8 next", rd_data, 8'h55);

    // R4 same-cycle release does not make room; R9 set beats clear
    do_reset();
    cyc(1, 0, 8'h61, 0, 0, 0, 0);
    cyc(1, 0, 8'h62, 0, 0, 0, 0);
    cyc(1, 0, 8'h63, 1, 0, 0, 0);
    chk("R4 concurrent overrun", {7'd0, overrun}, 8'd1);
    chk("R4 concurrent data", rd_data, 8'h62);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R4 dropped", {7'd0, rd_valid}, 8'd0);
    cyc(1, 0, 8'h64, 0, 0, 0, 0);
    cyc(1, 0, 8'h65, 0, 0, 0, 0);
    cyc(1, 0, 8'h66, 0, 0, 0, 1);
    chk("R9 set wins", {7'd0, overrun}, 8'd1);
    irq_en = 0; #1;
    chk("R10 disabled", {7'd0, rx_irq}, 8'd0);

    // Sweep: every 4-command sequence against the reference model
    for (int s = 0; s < 7*7*7*7; s++) begin
      irq_en = s[0];
      do_reset();
      for (int t = 0; t < 4; t++) begin
        int op = (s / (7 ** t)) % 7;
        logic [7:0] d = 8'(s * 4 + t);
        if (op == 2 && m_own_pending()) op = 0;
        cyc(op == 1 || op == 2, op == 2, d, op == 3, op == 4, op == 5, op == 6);
        m_apply(op, d);
        m_check();
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule